// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the host-side front end of an eight-input programmable interrupt controller. A byte-wide port with one address bit reaches two locations: the command location (address 0) and the data location (address 1). A command write with the select bit set begins a fresh initialization run. The data writes that follow are then taken in a fixed order: the vector base first, then the cascade configuration, then the mode byte if it was requested. Once that run ends, data writes load the interrupt mask.

The stored configuration drives a downstream priority resolver. It sees a per-input enable vector, which is the inverted mask gated by readiness. It also sees the vector base, the cascade byte and a set of mode status bits. The sequencer state machine has five states. S_UNINIT is entered from reset. S_WAIT_BASE is entered on the select write. S_WAIT_CASC is entered after the base is taken. S_WAIT_MODE is entered after the cascade byte, but only if the mode byte was requested. S_READY is entered after the cascade byte when no mode byte was requested, or after the mode byte. A select write moves every state back to S_WAIT_BASE.

Top module: `pic_init_seq`

## Requirements
- R1: After reset the block is uninitialized: `ready` is 0, `irq_en` is 0, a data read returns 8'hFF, `vec_base`, `cascade_cfg` and `upm_mode` are 0, `low_prio` and `slave_addr` are 7 and `spec_mask` is 0.
- R2: A write of address 0 with bit 4 set restarts initialization from any state. It clears `ready` and `upm_mode`, and the next address-1 write is taken as the vector base. `irq_en` stays 0 until the sequence completes.
- R3: That restart write clears the mask, so a data read returns 8'h00.
- R4: That restart write sets `low_prio` to 7, sets `slave_addr` to 7 and clears `spec_mask`.
- R5: The first data write after restart sets `vec_base` to the written byte with bits 2:0 forced to 0. The vector for input n is therefore `vec_base | n`.
- R6: The second data write after restart is stored unchanged in `cascade_cfg`. In a master it is the bitmap of inputs that have a slave attached; in a slave, bits 2:0 are the slave ID.
- R7: If bit 0 of the restart byte was 0, `ready` rises at the clock edge that takes the cascade byte, and the next data write is a mask write.
- R8: If bit 0 of the restart byte was 1, one more data write is taken as the mode byte, and its bit 0 sets `upm_mode`. `ready` stays 0 until that write, and rises at the clock edge that takes it.
- R9: While `ready` is 1, a data write loads the mask, where 1 masks an input. A data read returns the mask, and `irq_en` equals its inverse.
- R10: An address-0 write with bit 4 clear changes nothing. A data write before the first restart also changes nothing.
- R11: A restart issued while ready drops `ready` and `irq_en` to 0 and leaves the mask cleared. The vector base and cascade byte keep their old values until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 = command location, 1 = data location |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Mask when reading address 1, else 0 |
| ready | output | 1 | Initialization complete |
| irq_en | output | 8 | Per-input enable (inverted mask, 0 unless ready) |
| vec_base | output | 8 | Vector base, bits 2:0 zero |
| cascade_cfg | output | 8 | Cascade configuration byte |
| upm_mode | output | 1 | Processor-mode bit from the mode byte |
| low_prio | output | 3 | Input holding lowest priority |
| slave_addr | output | 3 | Slave-mode address |
| spec_mask | output | 1 | Special mask mode flag |

## Verification
The bound checker covers four rules on every cycle:
- a restart write always drops readiness and empties the mask;
- readiness only ever rises on a data write;
- a mask write while ready lands unchanged;
- a command write without the select bit leaves the outputs still.

The write order itself can only be shown by the bench's scenarios. These cover skipping or taking the mode byte depending on bit 0, the first data write landing as the base, and the base and cascade bytes surviving a restart. The bench also checks that a mask written before a repeated restart is gone afterwards.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
    typedef enum logic [2:0] {
        S_UNINIT,
        S_WAIT_BASE,
        S_WAIT_CASC,
        S_WAIT_MODE,
        S_READY
    } seq_state_t;

    localparam int SEL_BIT = 4;  // restart select bit in a command byte
    localparam int REQ_BIT = 0;  // mode-byte request bit in a restart byte
    localparam int UPM_BIT = 0;  // processor-mode bit in the mode byte
endpackage

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
    import pic_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       mode_req,
    input  logic       data_wr,
    output logic       take_base,
    output logic       take_casc,
    output logic       take_mode,
    output logic       take_mask,
    output logic       ready
);
    seq_state_t state_q, state_d;
    logic       req_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_UNINIT;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (restart) req_q <= mode_req;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = S_WAIT_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                S_UNINIT:    state_d = S_UNINIT;
                S_WAIT_BASE: state_d = S_WAIT_CASC;
                S_WAIT_CASC: state_d = req_q ? S_WAIT_MODE : S_READY;
                S_WAIT_MODE: state_d = S_READY;
                S_READY:     state_d = S_READY;
                default:     state_d = S_UNINIT;
            endcase
        end
    end

    // output decode
    always_comb begin
        take_base = 1'b0;
        take_casc = 1'b0;
        take_mode = 1'b0;
        take_mask = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            S_UNINIT:    ;
            S_WAIT_BASE: take_base = data_wr && !restart;
            S_WAIT_CASC: take_casc = data_wr && !restart;
            S_WAIT_MODE: take_mode = data_wr && !restart;
            S_READY: begin
                take_mask = data_wr && !restart;
                ready     = 1'b1;
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/pic_seq_regs.sv
module pic_seq_regs
    import pic_seq_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int IDW = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             take_base,
    input  logic             take_casc,
    input  logic             take_mode,
    input  logic             take_mask,
    input  logic [N_IRQ-1:0] wdata,
    output logic [N_IRQ-1:0] mask_q,
    output logic [N_IRQ-1:0] vec_q,
    output logic [N_IRQ-1:0] casc_q,
    output logic             upm_q,
    output logic [IDW-1:0]   low_prio_q,
    output logic [IDW-1:0]   slave_q,
    output logic             smm_q
);
    localparam logic [IDW-1:0] LAST_ID = IDW'(N_IRQ - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '1;
            vec_q      <= '0;
            casc_q     <= '0;
            upm_q      <= 1'b0;
            low_prio_q <= LAST_ID;
            slave_q    <= LAST_ID;
            smm_q      <= 1'b0;
        end else if (restart) begin
            mask_q     <= '0;
            upm_q      <= 1'b0;
            low_prio_q <= LAST_ID;
            slave_q    <= LAST_ID;
            smm_q      <= 1'b0;
        end else begin
            if (take_base) vec_q  <= {wdata[N_IRQ-1:IDW], {IDW{1'b0}}};
            if (take_casc) casc_q <= wdata;
            if (take_mode) upm_q  <= wdata[UPM_BIT];
            if (take_mask) mask_q <= wdata;
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ready,
    output logic [7:0] irq_en,
    output logic [7:0] vec_base,
    output logic [7:0] cascade_cfg,
    output logic       upm_mode,
    output logic [2:0] low_prio,
    output logic [2:0] slave_addr,
    output logic       spec_mask
);
    localparam int N_IRQ = 8;

    logic             restart, data_wr;
    logic             take_base, take_casc, take_mode, take_mask;
    logic [N_IRQ-1:0] mask_q;

    assign restart = wr_en && !addr && wdata[SEL_BIT];
    assign data_wr = wr_en && addr;

    pic_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .mode_req  (wdata[REQ_BIT]),
        .data_wr   (data_wr),
        .take_base (take_base),
        .take_casc (take_casc),
        .take_mode (take_mode),
        .take_mask (take_mask),
        .ready     (ready)
    );

    pic_seq_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .take_base  (take_base),
        .take_casc  (take_casc),
        .take_mode  (take_mode),
        .take_mask  (take_mask),
        .wdata      (wdata),
        .mask_q     (mask_q),
        .vec_q      (vec_base),
        .casc_q     (cascade_cfg),
        .upm_q      (upm_mode),
        .low_prio_q (low_prio),
        .slave_q    (slave_addr),
        .smm_q      (spec_mask)
    );

    assign rdata  = (rd_en && addr) ? mask_q : '0;
    assign irq_en = ready ? ~mask_q : '0;
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       ready,
    input logic [7:0] irq_en,
    input logic [7:0] vec_base,
    input logic [7:0] mask_q
);
    // R2: a restart write leaves the block not ready
    a_r2_restart_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> !ready);

    // R3: a restart write empties the mask
    a_r3_restart_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (mask_q == 8'h00));

    // R7 / R8: readiness only rises on a data write
    a_r7_ready_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(wr_en && addr));

    // R9: a mask write while ready lands unchanged
    a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && addr) |=> (mask_q == $past(wdata)));

    // R10: a command write without the select bit changes nothing
    a_r10_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && !wdata[4]) |=>
            ($stable(ready) && $stable(irq_en) && $stable(vec_base) && $stable(mask_q)));
endmodule

bind pic_init_seq pic_init_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ready    (ready),
    .irq_en   (irq_en),
    .vec_base (vec_base),
    .mask_q   (mask_q)
);

// File: tb/test_pic_init_seq.sv
`timescale 1ns/1ps
module test_pic_init_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, irq_en, vec_base, cascade_cfg;
    logic       ready, upm_mode, spec_mask;
    logic [2:0] low_prio, slave_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pic_init_seq i_pic_init_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .irq_en(irq_en),
        .vec_base(vec_base), .cascade_cfg(cascade_cfg), .upm_mode(upm_mode),
        .low_prio(low_prio), .slave_addr(slave_addr), .spec_mask(spec_mask)
    );

    // op: 1 = command write, 2 = data write
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [3:0] req;
        logic       rdy;
        logic [7:0] mask;
        logic [7:0] irq;
        logic [7:0] vec;
        logic [7:0] casc;
        logic       upm;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TBL [NROWS] = '{
        '{2'd2, 8'h55, 4'd10, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0}, // R10 data before init
        '{2'd1, 8'h10, 4'd3,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // R2 R3 restart, no mode byte
        '{2'd2, 8'h47, 4'd5,  1'b0, 8'h00, 8'h00, 8'h40, 8'h00, 1'b0}, // R5 base
        '{2'd2, 8'h04, 4'd7,  1'b1, 8'h00, 8'hFF, 8'h40, 8'h04, 1'b0}, // R6 R7 cascade, ready
        '{2'd2, 8'hFB, 4'd9,  1'b1, 8'hFB, 8'h04, 8'h40, 8'h04, 1'b0}, // R9 mask
        '{2'd1, 8'h00, 4'd10, 1'b1, 8'hFB, 8'h04, 8'h40, 8'h04, 1'b0}, // R10 ignored
        '{2'd1, 8'hEF, 4'd10, 1'b1, 8'hFB, 8'h04, 8'h40, 8'h04, 1'b0}, // R10 ignored, bit4 clear
        '{2'd1, 8'h11, 4'd11, 1'b0, 8'h00, 8'h00, 8'h40, 8'h04, 1'b0}, // R11 restart with mode byte
        '{2'd2, 8'h23, 4'd5,  1'b0, 8'h00, 8'h00, 8'h20, 8'h04, 1'b0}, // R5 new base
        '{2'd2, 8'h02, 4'd8,  1'b0, 8'h00, 8'h00, 8'h20, 8'h02, 1'b0}, // R8 waits for mode byte
        '{2'd2, 8'h01, 4'd8,  1'b1, 8'h00, 8'hFF, 8'h20, 8'h02, 1'b1}, // R8 mode byte, ready
        '{2'd2, 8'hA5, 4'd9,  1'b1, 8'hA5, 8'h5A, 8'h20, 8'h02, 1'b1}  // R9 mask
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns after the next falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic rd_mask(output logic [7:0] v);
        addr = 1'b1; rd_en = 1'b1; #0.5;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_mask(m);
        chk("R1 mask", m, 8'hFF);
        chk("R1 ready", {7'd0, ready}, 8'h00);
        chk("R1 irq_en", irq_en, 8'h00);
        chk("R1 vec_base", vec_base, 8'h00);
        chk("R1 low_prio", {5'd0, low_prio}, 8'h07);
        chk("R1 slave_addr", {5'd0, slave_addr}, 8'h07);
        chk("R1 spec_mask", {7'd0, spec_mask}, 8'h00);

        for (int i = 0; i < NROWS; i++) begin
            wr(TBL[i].op == 2'd2, TBL[i].data);
            rd_mask(m);
            chk($sformatf("row%0d R%0d mask", i, TBL[i].req), m, TBL[i].mask);
            chk($sformatf("row%0d R%0d ready", i, TBL[i].req), {7'd0, ready}, {7'd0, TBL[i].rdy});
            chk($sformatf("row%0d R%0d irq_en", i, TBL[i].req), irq_en, TBL[i].irq);
            chk($sformatf("row%0d R%0d vec", i, TBL[i].req), vec_base, TBL[i].vec);
            chk($sformatf("row%0d R%0d casc", i, TBL[i].req), cascade_cfg, TBL[i].casc);
            chk($sformatf("row%0d R%0d upm", i, TBL[i].req), {7'd0, upm_mode}, {7'd0, TBL[i].upm});
        end

        // R4: restart restores the priority, slave address and special mask
        wr(1'b0, 8'h1E);
        chk("R4 low_prio", {5'd0, low_prio}, 8'h07);
        chk("R4 slave_addr", {5'd0, slave_addr}, 8'h07);
        chk("R4 spec_mask", {7'd0, spec_mask}, 8'h00);
        chk("R2 upm cleared", {7'd0, upm_mode}, 8'h00);

        // R11: mask written, then restart again; mask must be cleared
        wr(1'b1, 8'hF8); wr(1'b1, 8'h80);
        wr(1'b1, 8'h3C);
        rd_mask(m);
        chk("R11 mask before restart", m, 8'h3C);
        wr(1'b0, 8'h10);
        rd_mask(m);
        chk("R11 mask after restart", m, 8'h00);
        chk("R11 irq_en after restart", irq_en, 8'h00);
        chk("R5 base kept over restart", vec_base, 8'hF8);

        // R1: reset mid-sequence returns to uninitialized
        wr(1'b1, 8'h08);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_mask(m);
        chk("R1 mask after reset", m, 8'hFF);
        chk("R1 vec after reset", vec_base, 8'h00);
        wr(1'b1, 8'h66);
        chk("R10 data after reset", vec_base, 8'h00);

        finish_run();
    end
endmodule